// File: doc/BRIEF.md
# Memory Bank Window Decoder

This block holds the control words for a set of memory banks and turns any system address into a bank selection. Each control word carries an 8 MiB aligned base, a ten-bit size code and an enable bit. For every address presented, the block reports which enabled bank the address falls in and the byte offset inside that bank. The result appears one clock after the address is applied.

Software reaches the control words in two ways. Each bank has its own register on a small device-control port. A second route goes through an index register and a data window register. The index picks a sub-register, and the data window reads or writes whatever that index selects. Indices 0 to 3 alias the bank control words. One further index returns a fixed memory-mode word.

Top module: `bank_decoder`

## Requirements
- R1: A write to a bank control word keeps only the bits set in mask 0xFFDEE001. Every other bit of that word reads back as zero, whichever access path did the write.
- R2: A bank's base address is its control word ANDed with 0xFF800000. Stored bits 22 and 20 therefore do not move the base.
- R3: Bank size in bytes is (1024 − code) × 8 MiB, where code is control-word bits [15:6]. Code 0 gives 8 GiB. An address hits a bank when base ≤ address < base + size. This compare is done at full precision, so a window may run past the top of the 32-bit address space.
- R4: Bit 0 of a control word enables its bank. A disabled bank never hits.
- R5: When several enabled banks match, the lowest-numbered bank wins. hit_vec is one-hot with bit i for bank i, or all zero on a miss. hit_valid is 1 exactly when hit_vec is non-zero.
- R6: hit_offset is the address minus the winning bank's base. It is zero on a miss.
- R7: hit_vec, hit_valid and hit_offset are registered. They reflect the sys_addr and control words present at the preceding rising clock edge.
- R8: Bank i's control word is at device-control address 0x040 + i. Reads on the port are combinational from dcr_addr. A write takes effect on the rising edge while dcr_wr is 1.
- R9: Address 0x010 is the index register. A write stores wdata[7:0], and a read returns the index zero-extended. Address 0x011 is the data window: it reads or writes the sub-register the index selects. Indices 0 to 3 are the control words of banks 0 to 3.
- R10: Index 0xE1 reads 0x20000000. This is a DDR-mode value of 1 in the two-bit field [30:29], ORed with 0x20000000. Writes to index 0xE1 change nothing.
- R11: Any other index reads as zero, and writes to it change nothing. Device-control addresses that are not mapped also read as zero.
- R12: An active-low reset clears every control word, the index register and the decoder outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcr_addr | input | 10 | Device-control register address |
| dcr_wr | input | 1 | Write strobe for the addressed register |
| dcr_wdata | input | 32 | Write data |
| dcr_rdata | output | 32 | Read data for dcr_addr (combinational) |
| sys_addr | input | 32 | System address to decode |
| hit_vec | output | 4 | One-hot bank hit, registered |
| hit_valid | output | 1 | Some enabled bank was hit, registered |
| hit_offset | output | 32 | Offset inside the winning bank, registered |

## Verification
The first address patterns sit exactly on window edges: the base, base + size − 1 and base + size. These separate an off-by-one in the limit compare from a wrong size scale. The overlap patterns place one address inside two enabled windows, first with the lower bank enabled and then with it disabled, which shows whether priority order and enable gating are both honoured. A control word with stray bits 22 and 20 set, a size code of zero, and an address just under the top of the 32-bit space test base masking, the 1024 minus code arithmetic and the wide compare. The indirect accesses write through the data window and read back on the direct port, and they also target the fixed index and an unmapped index, to show aliasing and write suppression.

// File: rtl/bank_decoder_pkg.sv
package bank_decoder_pkg;

   localparam int unsigned MODE_FIELD_LSB = 29;
   localparam logic [31:0] MODE_FLAG_BIT  = 32'h2000_0000;

   // Fixed memory-mode read value: a two-bit mode code placed at its field, plus a flag.
   function automatic logic [31:0] mode_word(input logic [1:0] code);
      return (32'(code) << MODE_FIELD_LSB) | MODE_FLAG_BIT;
   endfunction

   // Widest of two widths, used to size compare arithmetic.
   function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/bank_regfile.sv
module bank_regfile #(
   parameter int unsigned NB                    = 4,
   parameter int unsigned DW                    = 32,
   parameter int unsigned RAW                   = 10,
   parameter int unsigned IW                    = 8,
   parameter logic [RAW-1:0] BANK_REG_ADDR      = 10'h040,
   parameter logic [RAW-1:0] IDX_REG_ADDR       = 10'h010,
   parameter logic [RAW-1:0] WIN_REG_ADDR       = 10'h011,
   parameter logic [DW-1:0]  WRITE_MASK         = 32'hFFDE_E001,
   parameter logic [IW-1:0]  MODE_IDX           = 8'hE1,
   parameter logic [DW-1:0]  MODE_VALUE         = 32'h2000_0000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [RAW-1:0]         reg_addr,
   input  logic                   reg_wr,
   input  logic [DW-1:0]          reg_wdata,
   output logic [DW-1:0]          reg_rdata,
   output logic [NB-1:0][DW-1:0]  bank_q,
   output logic [IW-1:0]          idx_q
);

   logic          sel_idx;
   logic          sel_win;
   logic [DW-1:0] win_rdata;

   assign sel_idx = (reg_addr == IDX_REG_ADDR);
   assign sel_win = (reg_addr == WIN_REG_ADDR);

   // Index register for the indirect path.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (reg_wr && sel_idx)
         idx_q <= reg_wdata[IW-1:0];
   end

   // Per-bank control word storage, reachable directly and through the window.
   for (genvar g = 0; g < NB; g++) begin : g_bank
      logic wr_direct;
      logic wr_window;

      assign wr_direct = reg_wr && (reg_addr == BANK_REG_ADDR + RAW'(g));
      assign wr_window = reg_wr && sel_win && (idx_q == IW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank_q[g] <= '0;
         else if (wr_direct || wr_window)
            bank_q[g] <= reg_wdata & WRITE_MASK;
      end
   end

   // Indirect read: banks by index, the fixed mode word, zero elsewhere.
   always_comb begin
      win_rdata = '0;
      if (idx_q == MODE_IDX)
         win_rdata = MODE_VALUE;
      else
         for (int i = 0; i < NB; i++)
            if (idx_q == IW'(i))
               win_rdata = bank_q[i];
   end

   // Direct read mux.
   always_comb begin
      reg_rdata = '0;
      if (sel_idx)
         reg_rdata = DW'(idx_q);
      else if (sel_win)
         reg_rdata = win_rdata;
      else
         for (int i = 0; i < NB; i++)
            if (reg_addr == BANK_REG_ADDR + RAW'(i))
               reg_rdata = bank_q[i];
   end

endmodule

// File: rtl/bank_window.sv
module bank_window
   import bank_decoder_pkg::*;
#(
   parameter int unsigned DW          = 32,
   parameter int unsigned AW          = 32,
   parameter logic [DW-1:0] BASE_MASK = 32'hFF80_0000,
   parameter int unsigned SIZE_LSB    = 6,
   parameter int unsigned SIZE_W      = 10,
   parameter int unsigned GRAIN_LOG2  = 23
) (
   input  logic [DW-1:0] ctrl_word,
   input  logic [AW-1:0] addr,
   output logic          match,
   output logic [AW-1:0] offset
);

   localparam int unsigned CW = SIZE_W + 1;
   localparam int unsigned EW = wmax(AW, CW + GRAIN_LOG2) + 1;

   logic [SIZE_W-1:0] size_code;
   logic [CW-1:0]     unit_count;
   logic [AW-1:0]     base;
   logic [EW-1:0]     base_x;
   logic [EW-1:0]     addr_x;
   logic [EW-1:0]     limit_x;

   assign size_code  = ctrl_word[SIZE_LSB +: SIZE_W];
   assign unit_count = (CW'(1) << SIZE_W) - CW'(size_code);
   assign base       = AW'(ctrl_word & BASE_MASK);
   assign base_x     = EW'(base);
   assign addr_x     = EW'(addr);
   assign limit_x    = base_x + (EW'(unit_count) << GRAIN_LOG2);

   assign match  = ctrl_word[0] && (addr_x >= base_x) && (addr_x < limit_x);
   assign offset = addr - base;

endmodule

// File: rtl/hit_select.sv
module hit_select #(
   parameter int unsigned NB      = 4,
   parameter int unsigned AW      = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NB-1:0]         match,
   input  logic [NB-1:0][AW-1:0] offsets,
   output logic [NB-1:0]         hit_vec,
   output logic                  hit_valid,
   output logic [AW-1:0]         hit_offset
);

   logic [NB-1:0] sel_d;
   logic [AW-1:0] off_d;
   logic          found;

   // Lowest-numbered matching bank wins.
   always_comb begin
      sel_d = '0;
      off_d = '0;
      found = 1'b0;
      for (int i = 0; i < NB; i++) begin
         if (match[i] && !found) begin
            sel_d[i] = 1'b1;
            off_d    = offsets[i];
            found    = 1'b1;
         end
      end
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hit_vec    <= '0;
            hit_valid  <= 1'b0;
            hit_offset <= '0;
         end else begin
            hit_vec    <= sel_d;
            hit_valid  <= found;
            hit_offset <= off_d;
         end
      end
   end else begin : g_comb
      assign hit_vec    = sel_d;
      assign hit_valid  = found;
      assign hit_offset = off_d;
   end

endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
   import bank_decoder_pkg::*;
#(
   parameter int unsigned NB                = 4,
   parameter int unsigned DW                = 32,
   parameter int unsigned AW                = 32,
   parameter int unsigned RAW               = 10,
   parameter int unsigned IW                = 8,
   parameter logic [RAW-1:0] BANK_REG_ADDR  = 10'h040,
   parameter logic [RAW-1:0] IDX_REG_ADDR   = 10'h010,
   parameter logic [RAW-1:0] WIN_REG_ADDR   = 10'h011,
   parameter logic [DW-1:0]  WRITE_MASK     = 32'hFFDE_E001,
   parameter logic [DW-1:0]  BASE_MASK      = 32'hFF80_0000,
   parameter int unsigned SIZE_LSB          = 6,
   parameter int unsigned SIZE_W            = 10,
   parameter int unsigned GRAIN_LOG2        = 23,
   parameter logic [IW-1:0]  MODE_IDX       = 8'hE1,
   parameter logic [1:0]     MODE_CODE      = 2'd1,
   parameter bit             OUT_REG        = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [RAW-1:0] dcr_addr,
   input  logic           dcr_wr,
   input  logic [DW-1:0]  dcr_wdata,
   output logic [DW-1:0]  dcr_rdata,
   input  logic [AW-1:0]  sys_addr,
   output logic [NB-1:0]  hit_vec,
   output logic           hit_valid,
   output logic [AW-1:0]  hit_offset
);

   localparam logic [DW-1:0] MODE_VALUE = DW'(mode_word(MODE_CODE));

   initial begin
      assert (NB >= 1 && NB <= (1 << IW))
         else $error("bank count must fit the index range");
      assert (AW == DW)
         else $error("address and data widths must match");
      assert (SIZE_LSB + SIZE_W <= DW)
         else $error("size field outside control word");
      assert (32'(MODE_IDX) >= NB)
         else $error("mode index overlaps a bank index");
      assert (32'(BANK_REG_ADDR) + NB <= (1 << RAW))
         else $error("bank registers exceed the register space");
   end

   logic [NB-1:0][DW-1:0] bank_q;
   logic [IW-1:0]         idx_q;
   logic [NB-1:0]         match;
   logic [NB-1:0][AW-1:0] offsets;

   bank_regfile #(
      .NB(NB), .DW(DW), .RAW(RAW), .IW(IW),
      .BANK_REG_ADDR(BANK_REG_ADDR), .IDX_REG_ADDR(IDX_REG_ADDR),
      .WIN_REG_ADDR(WIN_REG_ADDR), .WRITE_MASK(WRITE_MASK),
      .MODE_IDX(MODE_IDX), .MODE_VALUE(MODE_VALUE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(dcr_addr), .reg_wr(dcr_wr), .reg_wdata(dcr_wdata),
      .reg_rdata(dcr_rdata), .bank_q(bank_q), .idx_q(idx_q)
   );

   for (genvar g = 0; g < NB; g++) begin : g_win
      bank_window #(
         .DW(DW), .AW(AW), .BASE_MASK(BASE_MASK), .SIZE_LSB(SIZE_LSB),
         .SIZE_W(SIZE_W), .GRAIN_LOG2(GRAIN_LOG2)
      ) u_win (
         .ctrl_word(bank_q[g]), .addr(sys_addr),
         .match(match[g]), .offset(offsets[g])
      );
   end

   hit_select #(.NB(NB), .AW(AW), .OUT_REG(OUT_REG)) u_sel (
      .clk(clk), .rst_n(rst_n), .match(match), .offsets(offsets),
      .hit_vec(hit_vec), .hit_valid(hit_valid), .hit_offset(hit_offset)
   );

endmodule

// File: rtl/bank_decoder_chk.sv
module bank_decoder_chk #(
   parameter int unsigned NB               = 4,
   parameter int unsigned DW               = 32,
   parameter int unsigned AW               = 32,
   parameter int unsigned RAW              = 10,
   parameter int unsigned IW               = 8,
   parameter logic [RAW-1:0] IDX_REG_ADDR  = 10'h010,
   parameter logic [RAW-1:0] WIN_REG_ADDR  = 10'h011,
   parameter logic [DW-1:0]  WRITE_MASK    = 32'hFFDE_E001,
   parameter logic [IW-1:0]  MODE_IDX      = 8'hE1,
   parameter logic [DW-1:0]  MODE_VALUE    = 32'h2000_0000,
   parameter bit             OUT_REG       = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [RAW-1:0]        dcr_addr,
   input logic [DW-1:0]         dcr_rdata,
   input logic [NB-1:0]         hit_vec,
   input logic                  hit_valid,
   input logic [AW-1:0]         hit_offset,
   input logic [NB-1:0][DW-1:0] bank_q,
   input logic [IW-1:0]         idx_q
);

   assert_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   assert_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid == (hit_vec != '0));

   assert_miss_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_valid |-> hit_offset == '0);

   assert_mode_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dcr_addr == WIN_REG_ADDR && idx_q == MODE_IDX) |-> dcr_rdata == MODE_VALUE);

   assert_index_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dcr_addr == IDX_REG_ADDR) |-> dcr_rdata == DW'(idx_q));

   assert_reset_clear_R12: assert property (@(posedge clk)
      $rose(rst_n) |-> (bank_q == '0 && idx_q == '0 && !hit_valid));

   for (genvar g = 0; g < NB; g++) begin : g_bank_chk
      assert_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (bank_q[g] & ~WRITE_MASK) == '0);
      if (OUT_REG) begin : g_en
         assert_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[g] |-> $past(bank_q[g][0]));
      end
   end

endmodule

bind bank_decoder bank_decoder_chk #(
   .NB(NB), .DW(DW), .AW(AW), .RAW(RAW), .IW(IW),
   .IDX_REG_ADDR(IDX_REG_ADDR), .WIN_REG_ADDR(WIN_REG_ADDR),
   .WRITE_MASK(WRITE_MASK), .MODE_IDX(MODE_IDX), .MODE_VALUE(MODE_VALUE),
   .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .dcr_addr(dcr_addr), .dcr_rdata(dcr_rdata),
   .hit_vec(hit_vec), .hit_valid(hit_valid), .hit_offset(hit_offset),
   .bank_q(bank_q), .idx_q(idx_q)
);

// File: tb/sim_bank_decoder.sv
`timescale 1ns/1ps
module sim_bank_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  dcr_addr = '0;
   logic        dcr_wr = 1'b0;
   logic [31:0] dcr_wdata = '0;
   logic [31:0] dcr_rdata;
   logic [31:0] sys_addr = '0;
   logic [3:0]  hit_vec;
   logic        hit_valid;
   logic [31:0] hit_offset;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   typedef struct {
      logic [3:0]  vec;
      logic        valid;
      logic [31:0] off;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   bank_decoder u0 (
      .clk(clk), .rst_n(rst_n), .dcr_addr(dcr_addr), .dcr_wr(dcr_wr),
      .dcr_wdata(dcr_wdata), .dcr_rdata(dcr_rdata), .sys_addr(sys_addr),
      .hit_vec(hit_vec), .hit_valid(hit_valid), .hit_offset(hit_offset)
   );

   task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      dcr_addr = a; dcr_wdata = d; dcr_wr = 1'b1;
      @(posedge clk);
      #1 dcr_wr = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [9:0] a, input logic [31:0] exp);
      @(negedge clk);
      dcr_addr = a; dcr_wr = 1'b0;
      #1 check32(tag, dcr_rdata, exp);
   endtask

   // Driver: present an address and queue what the decoder must report one edge later.
   task automatic probe(input string tag, input logic [31:0] a, input logic [3:0] vec,
                        input logic [31:0] off);
      exp_t e;
      @(negedge clk);
      sys_addr = a;
      e.vec = vec; e.valid = (vec != 4'b0); e.off = off; e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: compare the registered result after each edge (R7 latency).
   always @(posedge clk) begin
      #1;
      if (sb.size() != 0) begin
         exp_t e;
         e = sb.pop_front();
         check32({e.tag, " R7 hit_vec"},    32'(hit_vec),   32'(e.vec));
         check32({e.tag, " R7 hit_valid"},  32'(hit_valid), 32'(e.valid));
         check32({e.tag, " R6 hit_offset"}, hit_offset,     e.off);
      end
   end

   task automatic drain;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12: reset state
      rd("R12 bank0", 10'h040, 32'h0);
      rd("R12 bank3", 10'h043, 32'h0);
      rd("R12 index", 10'h010, 32'h0);
      check32("R12 hit_valid", 32'(hit_valid), 32'h0);

      // R1: write mask on direct path; R8 direct addressing
      wr(10'h040, 32'hFFFF_FFFF);
      rd("R1 R8 bank0 masked", 10'h040, 32'hFFDE_E001);
      // base 0xFF800000, 1 GiB window
      probe("R2 base edge", 32'hFF80_0000, 4'b0001, 32'h0);
      probe("R3 in window", 32'hFFFF_FFFF, 4'b0001, 32'h007F_FFFF);
      probe("R2 below base", 32'hFF7F_FFFF, 4'b0000, 32'h0);
      drain();

      wr(10'h040, 32'h0000_E001);   // base 0, 1 GiB
      wr(10'h041, 32'h4000_C001);   // base 0x40000000, 2 GiB
      wr(10'h042, 32'h4080_E001);   // base 0x40800000, 1 GiB
      wr(10'h043, 32'hC070_E001);   // base 0xC0000000 despite bits 22/20
      rd("R1 bank3 masked", 10'h043, 32'hC050_E001);
      probe("R3 last byte", 32'h3FFF_FFFF, 4'b0001, 32'h3FFF_FFFF);
      probe("R3 limit is next bank", 32'h4000_0000, 4'b0010, 32'h0);
      probe("R3 bank1 mid", 32'h8000_0010, 4'b0010, 32'h4000_0010);
      probe("R5 overlap low wins", 32'h4080_0004, 4'b0010, 32'h0080_0004);
      probe("R3 bank1 top", 32'hBFFF_FFFF, 4'b0010, 32'h7FFF_FFFF);
      probe("R2 masked base", 32'hC000_0000, 4'b1000, 32'h0);
      probe("R3 wide compare", 32'hFFFF_FFFF, 4'b1000, 32'h3FFF_FFFF);
      drain();

      // R4: disable bank1
      wr(10'h041, 32'h4000_C000);
      probe("R4 R5 overlap falls to bank2", 32'h4080_0004, 4'b0100, 32'h4);
      probe("R4 disabled miss", 32'h4000_0000, 4'b0000, 32'h0);
      probe("R4 bank2 inner", 32'h8000_0010, 4'b0100, 32'h3F80_0010);
      probe("R4 gap miss", 32'h9000_0000, 4'b0000, 32'h0);
      drain();

      // R3: size code 0 -> 8 GiB covers all, R5 lowest wins
      wr(10'h040, 32'h0000_0001);
      probe("R3 R5 code zero", 32'hC000_0000, 4'b0001, 32'hC000_0000);
      drain();

      // R9: indirect path
      wr(10'h010, 32'h0000_0002);
      rd("R9 index readback", 10'h010, 32'h2);
      wr(10'h011, 32'h1234_5678);
      rd("R9 R1 alias direct", 10'h042, 32'h1214_4000);
      rd("R9 window read", 10'h011, 32'h1214_4000);

      // R10: fixed mode word
      wr(10'h010, 32'h0000_01E1);
      rd("R9 index 8 bits", 10'h010, 32'h0000_00E1);
      rd("R10 mode read", 10'h011, 32'h2000_0000);
      wr(10'h011, 32'hFFFF_FFFF);
      rd("R10 mode after write", 10'h011, 32'h2000_0000);
      rd("R10 bank0 untouched", 10'h040, 32'h0000_0001);
      rd("R10 bank3 untouched", 10'h043, 32'hC050_E001);

      // R11: unmapped index and address
      wr(10'h010, 32'h0000_0055);
      rd("R11 unmapped index", 10'h011, 32'h0);
      wr(10'h011, 32'hFFFF_FFFF);
      rd("R11 after write", 10'h011, 32'h0);
      rd("R11 bank1 untouched", 10'h041, 32'h4000_C000);
      rd("R11 bank2 untouched", 10'h042, 32'h1214_4000);
      rd("R11 unmapped addr", 10'h3FF, 32'h0);

      // R12: reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check32("R12 outputs in reset", 32'(hit_valid), 32'h0);
      rst_n = 1'b1;
      rd("R12 bank0 cleared", 10'h040, 32'h0);
      rd("R12 bank3 cleared", 10'h043, 32'h0);
      rd("R12 index cleared", 10'h010, 32'h0);
      probe("R12 R4 no bank after reset", 32'h0000_0010, 4'b0000, 32'h0);
      drain();

      check32("R7 scoreboard drained", 32'(sb.size()), 32'h0);

      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule